// File: doc/BRIEF.md
# Interrupt-Controller Countdown Timer

This block is the local timer of an interrupt controller. Software sets it up through a 32-bit register port, selected by a 12-bit byte offset. There are four registers: a timer control entry, a start value, a live count and a divide setting. The control entry holds the interrupt vector, a mask bit, the one-shot or periodic choice and the source of the count ticks.

A write to the start value loads the counter and restarts the prescaler. After that the counter steps down by one on each selected tick. When it reaches zero, the block emits a single-cycle interrupt request that carries the vector, unless the entry is masked. Prioritising and delivering that request is left to logic outside the block.

Software can read the current count at any moment. In periodic mode the counter refills from the start value. In one-shot mode it rests at zero until software writes a new start value.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the control entry reads 0x0001_0000 (masked, one-shot, raw clock base, vector 0). The start value, current count and divide registers read 0, and `irq_pulse` is low.
- R2: The register offsets are: control entry 0x320, start value 0x380, current count 0x390 (read-only, so writes to it are ignored), divide 0x3E0. Only bits 3, 1 and 0 of the divide register are stored, and bit 2 reads 0. Any other offset reads 0 and ignores writes.
- R3: With the tick base set to the divider (entry bits 19:18 = 10), the divide codes map as follows: 0x0=/2, 0x1=/4, 0x2=/8, 0x3=/16, 0x8=/32, 0x9=/64, 0xA=/128, 0xB=/1. The expiry pulse appears N×divisor cycles after the clock edge that takes a start value of N.
- R4: With tick base 00, the counter steps down once per clock, and the pulse appears N cycles after the start write.
- R5: With tick base 01, the counter steps down only in cycles where `alt_tick` is high. With base 11 it never steps down.
- R6: The current-count register reads the start value right after the write, then reads the decreasing value as ticks arrive.
- R7: On expiry, `irq_pulse` is high for exactly one cycle, and `irq_vector` then equals entry bits 7:0. At all other times `irq_vector` is 0.
- R8: When entry bit 16 (mask) is set, expiry raises no pulse, but the count still steps down to zero.
- R9: In one-shot mode (entry bit 17 = 0), the count holds at zero after expiry and raises no further pulse.
- R10: In periodic mode (entry bit 17 = 1), the count reads zero for one cycle and then refills from the start value. The interval between pulses is N×divisor cycles for divisors of 2 or more, and N+1 cycles when every clock is a tick.
- R11: Writing a start value of 0 stops the timer. The count reads 0 and no pulse is raised.
- R12: Writing a new start value while the timer runs restarts it from the new value, with the prescaler phase cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high together with bus_sel |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| alt_tick | input | 1 | Alternate time-base strobe |
| irq_pulse | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector carried with irq_pulse |

## Verification
The bench measures the exact expiry cycle for all eight divide codes. A design that decoded the split code wrongly would miss by a power of two, and one that left the prescaler phase uncleared would fire early. Periodic runs check the gap between pulses and the one-cycle zero before the refill, so an off-by-one in the refill shows up as a shifted second pulse. The masked case, the zero start value and a restart in mid-count each catch a design that pulses when it should stay quiet or keeps the stale count. The bench also checks the reserved and read-only offsets, and looks for a stray second pulse in one-shot mode.

// File: rtl/lct_pkg.sv
package lct_pkg;
    localparam int REG_W  = 32;
    localparam int ADR_W  = 12;
    localparam int VEC_W  = 8;

    localparam logic [ADR_W-1:0] OFS_ENTRY = 12'h320;
    localparam logic [ADR_W-1:0] OFS_START = 12'h380;
    localparam logic [ADR_W-1:0] OFS_LIVE  = 12'h390;
    localparam logic [ADR_W-1:0] OFS_DIV   = 12'h3E0;

    typedef enum logic [1:0] {
        BASE_RAW = 2'b00,
        BASE_ALT = 2'b01,
        BASE_DIV = 2'b10,
        BASE_OFF = 2'b11
    } tick_base_e;

    typedef struct packed {
        tick_base_e       base;
        logic             periodic;
        logic             mask;
        logic [VEC_W-1:0] vector;
    } entry_t;

    localparam entry_t ENTRY_RST = '{base: BASE_RAW, periodic: 1'b0,
                                     mask: 1'b1, vector: '0};
endpackage

// File: rtl/lct_prescaler.sv
module lct_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [3:0] div_code,
    output logic       tick
);
    localparam int SEL_W = $clog2(PRE_W + 1);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t      st_d, st_q;
    logic [SEL_W-1:0] shift;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] mask_w;

    always_comb begin
        // split code: bits {3,1,0} plus one give log2 of the divisor, wrapping to /1
        shift  = SEL_W'({div_code[3], div_code[1:0]}) + SEL_W'(1);
        span   = (PRE_W+1)'(1) << shift;
        mask_w = PRE_W'(span - (PRE_W+1)'(1));
        tick   = (st_q.phase & mask_w) == mask_w;
        st_d   = st_q;
        if (restart) st_d.phase = '0;
        else         st_d.phase = st_q.phase + PRE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lct_regs.sv
module lct_regs
    import lct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0] live_count,
    output entry_t           entry,
    output logic [CNT_W-1:0] start_val,
    output logic [3:0]       div_code,
    output logic             start_wr
);
    typedef struct packed {
        entry_t           entry;
        logic [CNT_W-1:0] start;
        logic [3:0]       div;
    } reg_state_t;

    reg_state_t rs_d, rs_q;
    logic       wr;

    always_comb begin
        wr       = bus_sel && bus_wr;
        start_wr = wr && (bus_addr == OFS_START);
        rs_d     = rs_q;
        if (wr && bus_addr == OFS_ENTRY) begin
            rs_d.entry.vector   = bus_wdata[7:0];
            rs_d.entry.mask     = bus_wdata[16];
            rs_d.entry.periodic = bus_wdata[17];
            rs_d.entry.base     = tick_base_e'(bus_wdata[19:18]);
        end
        if (start_wr)
            rs_d.start = bus_wdata[CNT_W-1:0];
        if (wr && bus_addr == OFS_DIV)
            rs_d.div = {bus_wdata[3], 1'b0, bus_wdata[1:0]};

        case (bus_addr)
            OFS_ENTRY: bus_rdata = {12'h0, rs_q.entry.base, rs_q.entry.periodic,
                                    rs_q.entry.mask, 8'h0, rs_q.entry.vector};
            OFS_START: bus_rdata = REG_W'(rs_q.start);
            OFS_LIVE:  bus_rdata = REG_W'(live_count);
            OFS_DIV:   bus_rdata = {28'h0, rs_q.div};
            default:   bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q.entry <= ENTRY_RST;
            rs_q.start <= '0;
            rs_q.div   <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign entry     = rs_q.entry;
    assign start_val = rs_q.start;
    assign div_code  = rs_q.div;
endmodule

// File: rtl/lct_counter.sv
module lct_counter
    import lct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start_wr,
    input  logic [CNT_W-1:0] start_new,
    input  logic [CNT_W-1:0] reload_val,
    input  entry_t           entry,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             irq_pulse,
    output logic [VEC_W-1:0] irq_vector
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             run;
        logic             pulse;
        logic [VEC_W-1:0] vec;
    } cnt_state_t;

    cnt_state_t cs_d, cs_q;

    always_comb begin
        cs_d       = cs_q;
        cs_d.pulse = 1'b0;
        cs_d.vec   = '0;
        if (start_wr) begin
            cs_d.count = start_new;
            cs_d.run   = start_new != '0;
        end else if (cs_q.run) begin
            if (cs_q.count == '0) begin
                // only a periodic run reaches here still armed
                cs_d.count = reload_val;
            end else if (tick) begin
                cs_d.count = cs_q.count - CNT_W'(1);
                if (cs_q.count == CNT_W'(1)) begin
                    cs_d.run   = entry.periodic;
                    cs_d.pulse = !entry.mask;
                    cs_d.vec   = entry.mask ? '0 : entry.vector;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign count      = cs_q.count;
    assign running    = cs_q.run;
    assign irq_pulse  = cs_q.pulse;
    assign irq_vector = cs_q.vec;
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
    import lct_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        alt_tick,
    output logic        irq_pulse,
    output logic [7:0]  irq_vector
);
    entry_t           entry;
    logic [CNT_W-1:0] start_val;
    logic [CNT_W-1:0] cur_count;
    logic [3:0]       div_code;
    logic             start_wr;
    logic             div_tick;
    logic             tick_sel;
    logic             running;
    logic             mask_on;

    lct_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .live_count(cur_count), .entry(entry), .start_val(start_val),
        .div_code(div_code), .start_wr(start_wr)
    );

    lct_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(start_wr),
        .div_code(div_code), .tick(div_tick)
    );

    always_comb begin
        case (entry.base)
            BASE_RAW: tick_sel = 1'b1;
            BASE_ALT: tick_sel = alt_tick;
            BASE_DIV: tick_sel = div_tick;
            default:  tick_sel = 1'b0;
        endcase
    end

    assign mask_on = entry.mask;

    lct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_sel),
        .start_wr(start_wr), .start_new(bus_wdata[CNT_W-1:0]),
        .reload_val(start_val), .entry(entry),
        .count(cur_count), .running(running),
        .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );
endmodule

// File: rtl/lct_checker.sv
module lct_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_pulse,
    input logic [7:0]       irq_vector,
    input logic [CNT_W-1:0] cur_count,
    input logic             running,
    input logic             start_wr,
    input logic             mask_on
);
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    a_r7_quiet_vector: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pulse |-> irq_vector == 8'h0);

    a_r8_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_on && !start_wr) |=> !irq_pulse);

    a_r9_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> cur_count == '0);

    a_r6_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count != '0 && !start_wr) |=> cur_count <= $past(cur_count));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start_wr) |=> $stable(cur_count));
endmodule

bind irq_countdown_timer lct_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .irq_vector(irq_vector),
    .cur_count(cur_count), .running(running), .start_wr(start_wr),
    .mask_on(mask_on)
);

// File: tb/tb_irq_countdown_timer.sv
module tb_irq_countdown_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alt_tick = 1'b0;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_countdown_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alt_tick(alt_tick), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_pulse(input int limit, output int n);
        n = 0;
        while (!irq_pulse && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_pulses(input int cyc, output int p);
        p = 0;
        for (int i = 0; i < cyc; i++) begin
            if (irq_pulse) p++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(12'h320, v); check("R1 entry", v, 32'h0001_0000);
        rd(12'h380, v); check("R1 start", v, 0);
        rd(12'h390, v); check("R1 live", v, 0);
        rd(12'h3E0, v); check("R1 div", v, 0);
        check("R1 irq", {31'h0, irq_pulse}, 0);
    endtask

    task automatic t_offsets;
        logic [31:0] v;
        wr(12'h390, 32'h5);
        rd(12'h390, v); check("R2 live read-only", v, 0);
        wr(12'h300, 32'hFFFF_FFFF);
        rd(12'h300, v); check("R2 unmapped", v, 0);
        wr(12'h3E0, 32'hF);
        rd(12'h3E0, v); check("R2 div bit2", v, 32'hB);
        wr(12'h320, 32'hFFFF_FFFF);
        rd(12'h320, v); check("R2 entry fields", v, 32'h000F_00FF);
        wr(12'h320, 32'h0001_0000);
    endtask

    task automatic t_divide;
        int codes [8] = '{0, 1, 2, 3, 8, 9, 10, 11};
        int dvs   [8] = '{2, 4, 8, 16, 32, 64, 128, 1};
        int n, p;
        logic [31:0] v;
        wr(12'h320, 32'h0008_0040 | 32'h0);
        for (int i = 0; i < 8; i++) begin
            wr(12'h3E0, 32'(codes[i]));
            wr(12'h380, 32'd3);
            wait_pulse(1000, n);
            check("R3 expiry cycle", 32'(n), 32'(3 * dvs[i]));
            check("R7 vector", {24'h0, irq_vector}, 32'h40);
            @(negedge clk);
            check("R7 one cycle", {31'h0, irq_pulse}, 0);
        end
        count_pulses(300, p);
        check("R9 no repeat", 32'(p), 0);
        rd(12'h390, v); check("R9 holds zero", v, 0);
    endtask

    task automatic t_raw;
        int n;
        wr(12'h320, 32'h0000_0041);
        wr(12'h380, 32'd5);
        wait_pulse(100, n);
        check("R4 raw expiry", 32'(n), 5);
        check("R7 raw vector", {24'h0, irq_vector}, 32'h41);
    endtask

    task automatic t_alt;
        logic [31:0] v;
        int p;
        wr(12'h320, 32'h0004_0042);
        wr(12'h380, 32'd3);
        repeat (6) @(negedge clk);
        rd(12'h390, v); check("R5 no alt tick", v, 3);
        alt_tick = 1'b1; @(negedge clk); alt_tick = 1'b0;
        repeat (4) @(negedge clk);
        rd(12'h390, v); check("R5 one alt tick", v, 2);
        alt_tick = 1'b1; @(negedge clk); @(negedge clk); alt_tick = 1'b0;
        check("R5 alt expiry", {31'h0, irq_pulse}, 1);
        check("R5 alt vector", {24'h0, irq_vector}, 32'h42);
        wr(12'h320, 32'h000C_0042);
        wr(12'h380, 32'd5);
        count_pulses(20, p);
        rd(12'h390, v); check("R5 base off", v, 5);
        wr(12'h380, 32'd0);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        wr(12'h320, 32'h0008_0043);
        wr(12'h3E0, 32'h1);
        wr(12'h380, 32'd10);
        rd(12'h390, v); check("R6 initial", v, 10);
        repeat (8) @(negedge clk);
        rd(12'h390, v); check("R6 decreasing", v, 8);
        wr(12'h380, 32'd0);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        int p;
        wr(12'h320, 32'h0009_0044);
        wr(12'h3E0, 32'h0);
        wr(12'h380, 32'd4);
        repeat (4) @(negedge clk);
        rd(12'h390, v); check("R8 still counts", v, 2);
        count_pulses(20, p);
        check("R8 no pulse", 32'(p), 0);
        rd(12'h390, v); check("R8 reached zero", v, 0);
    endtask

    task automatic t_periodic;
        logic [31:0] v;
        int n;
        wr(12'h320, 32'h000A_0045);
        wr(12'h3E0, 32'h1);
        wr(12'h380, 32'd3);
        wait_pulse(100, n);
        check("R10 first", 32'(n), 12);
        rd(12'h390, v); check("R10 zero cycle", v, 0);
        @(negedge clk);
        rd(12'h390, v); check("R10 refill", v, 3);
        wait_pulse(100, n);
        check("R10 div interval", 32'(n + 1), 12);
        wr(12'h320, 32'h0002_0045);
        wr(12'h380, 32'd3);
        wait_pulse(100, n);
        check("R10 raw first", 32'(n), 3);
        @(negedge clk);
        wait_pulse(100, n);
        check("R10 raw interval", 32'(n + 1), 4);
    endtask

    task automatic t_zero;
        logic [31:0] v;
        int p;
        wr(12'h380, 32'd0);
        count_pulses(60, p);
        check("R11 no pulse", 32'(p), 0);
        rd(12'h390, v); check("R11 count zero", v, 0);
    endtask

    task automatic t_restart;
        int n;
        wr(12'h320, 32'h0008_0046);
        wr(12'h3E0, 32'h0);
        wr(12'h380, 32'd10);
        repeat (5) @(negedge clk);
        wr(12'h380, 32'd2);
        wait_pulse(100, n);
        check("R12 restart expiry", 32'(n), 4);
        check("R12 vector", {24'h0, irq_vector}, 32'h46);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_offsets();
        t_divide();
        t_raw();
        t_alt();
        t_readback();
        t_mask();
        t_periodic();
        t_zero();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule